// File: doc/BRIEF.md
# FM Synthesizer Native-Mode Register File

This block is the host-facing parameter store of an FM synthesizer with 18 channels of four operators each, running in its native addressing mode. A host presents an 11-bit register address with either a write strobe and an 8-bit data byte, or a read strobe. The address picks one of four targets:

- one byte of an operator's eight-byte parameter set,
- a per-channel key-on and four-operator-enable pair,
- the split key-on pairs of the two highest channels,
- or one of three global control registers.

Operator bytes live in a RAM-style array indexed directly by the address. Channel and global fields are kept in flops and driven out as ports for the rest of the synthesizer.

Reads take one clock: `rd_valid` rises the cycle after `rd_en`, with the byte on `rdata`. A few readbacks do not return the byte as written, and the requirements give these exactly. Each write to an operator's envelope-delay byte is compared with the delay already stored for that operator. A one-cycle pulse reports whether the value went up or down.

Top module: `fmnr_regfile`

## Requirements
- R1: After a synchronous active-low reset, every key-on and four-operator output is 0, `ks_mode` and `eg_halt` are 0, `dly_rise`, `dly_fall` and `rd_valid` are 0, and a read of key-on address 576 returns 0x00.
- R2: Addresses 0 to 575 address operator storage, with channel = addr[9:5], operator = addr[4:3] and byte index = addr[2:0]. A read returns the last byte written there, on `rdata` with `rd_valid` high, in the cycle after `rd_en`. `rd_valid` is low in a cycle that follows no read.
- R3: Reading operator byte index 0 returns bit 6 of the stored byte in bit position 4. All other bits come back as written.
- R4: A write to operator byte index 5 compares bits 7:5 of the new byte with the delay stored for that operator (0 after reset). If the new value is larger, `dly_rise` is high for the one cycle after the write. If it is smaller, `dly_fall` is high for that cycle. Equal values, and writes to any other byte index, raise neither.
- R5: Addresses 576 to 591 hold the pair for channels 0 to 15 (channel = addr − 576). Written bit 0 drives `key_on[ch]` and written bit 1 drives `fourop[ch]`. A read returns those two bits in the same positions, with bits 7:2 zero.
- R6: Addresses 592 to 595 serve channels 16 and 17, with channel = 16 + addr[1]. When addr[0] is 0, bits 1:0 go to `fourop[ch]` and `key_on[ch]`. When addr[0] is 1, they go to `fourop_hi[ch-16]` and `key_on_hi[ch-16]`, which serve operators 2 and 3. Readback uses the same bit positions as R5.
- R7: A write to 0x504 sets `fourop[2:0]` from bits 2:0 and `fourop[11:9]` from bits 5:3, ignoring bits 7:6. A read of 0x504 returns those six enables in the same positions, with bits 7:6 zero.
- R8: A write to 0x408 sets `ks_mode` from bit 6. A read returns `ks_mode` in bit 6, with every other bit zero.
- R9: A write to 0x501 stores the byte, and `eg_halt` becomes the OR of written bits 0 and 5. A read of 0x501 returns written bit 5 in bit 0 and `eg_halt` in bit 5. Bits 7:6 and 4:1 come back as written.
- R10: Any address not named in R2 and R5 to R9 reads as 0x00. A write to such an address changes no output and no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | 11 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High the cycle after a read strobe |
| dly_rise | output | 1 | Envelope-delay increase pulse |
| dly_fall | output | 1 | Envelope-delay decrease pulse |
| key_on | output | 18 | Per-channel key-on (main half) |
| fourop | output | 18 | Per-channel four-operator enable (main half) |
| key_on_hi | output | 2 | Second-half key-on of channels 16 and 17 |
| fourop_hi | output | 2 | Second-half four-operator enable of channels 16 and 17 |
| ks_mode | output | 1 | Key-scale note-select mode |
| eg_halt | output | 1 | Envelope-halt test control |

## Verification
The bench builds the block with its default parameters: 18 channels, four operators, eight bytes per operator and two split channels. With these values the address map ends exactly at the boundaries R2, R5 and R6 describe. The last operator cell (575), the first key-on address (576), the split window (592 to 595) and the first unmapped address above it (596) all become reachable as real edges. The same holds for the two groups that register 0x504 touches (channels 0 to 2 and 9 to 11).

// File: rtl/fmnr_pkg.sv
// Shared types and fixed address constants for the FM native register file.
// Assumes the 11-bit native address map; global register addresses are fixed.
package fmnr_pkg;
    localparam int ADDR_W   = 11;
    localparam int DATA_W   = 8;
    localparam int DLY_REG  = 5;   // operator byte carrying the envelope delay
    localparam int MODE_REG = 0;   // operator byte with the readback bit swap

    localparam logic [ADDR_W-1:0] A_KSMODE = 11'h408;
    localparam logic [ADDR_W-1:0] A_TEST   = 11'h501;
    localparam logic [ADDR_W-1:0] A_QUAD   = 11'h504;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_OPER,
        RG_KEY,
        RG_SPLIT,
        RG_KSMODE,
        RG_TEST,
        RG_QUAD
    } region_e;
endpackage

// File: rtl/fmnr_decode.sv
// Address decoder: classifies an address into a region and extracts the
// channel and half-select for key-on accesses. Purely combinational.
// Assumes operator storage is linear in the address (channel stride 32).
module fmnr_decode
    import fmnr_pkg::*;
#(
    parameter int NUM_CH   = 18,
    parameter int NUM_OP   = 4,
    parameter int NUM_REG  = 8,
    parameter int SPLIT_CH = 2,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [CH_W-1:0]   ch,
    output logic              half
);
    localparam int OPER_SPAN = NUM_CH * NUM_OP * NUM_REG;
    localparam logic [ADDR_W-1:0] KEY_BASE_A   = ADDR_W'(OPER_SPAN);
    localparam logic [ADDR_W-1:0] SPLIT_BASE_A = ADDR_W'(OPER_SPAN + NUM_CH - SPLIT_CH);
    localparam logic [ADDR_W-1:0] SPLIT_END_A  = ADDR_W'(OPER_SPAN + NUM_CH + SPLIT_CH);

    logic [ADDR_W-1:0] key_off;
    logic [ADDR_W-1:0] split_off;

    assign key_off   = addr - KEY_BASE_A;
    assign split_off = addr - SPLIT_BASE_A;

    // Region classification and channel extraction
    always_comb begin
        region = RG_NONE;
        ch     = '0;
        half   = 1'b0;
        if (addr < KEY_BASE_A) begin
            region = RG_OPER;
        end else if (addr < SPLIT_BASE_A) begin
            region = RG_KEY;
            ch     = key_off[CH_W-1:0];
        end else if (addr < SPLIT_END_A) begin
            region = RG_SPLIT;
            ch     = CH_W'(NUM_CH - SPLIT_CH) + split_off[CH_W:1];
            half   = split_off[0];
        end else if (addr == A_KSMODE) begin
            region = RG_KSMODE;
        end else if (addr == A_TEST) begin
            region = RG_TEST;
        end else if (addr == A_QUAD) begin
            region = RG_QUAD;
        end
    end
endmodule

// File: rtl/fmnr_op_store.sv
// Operator parameter storage: synchronous RAM of bytes indexed by the
// linear operator address, with one-cycle registered read and the byte-0
// readback substitution. Keeps a flop shadow of every operator's delay
// field so a write can be compared in the same cycle.
// Assumes we/re are only asserted for addresses inside the operator span.
module fmnr_op_store
    import fmnr_pkg::*;
#(
    parameter int NUM_CH  = 18,
    parameter int NUM_OP  = 4,
    parameter int NUM_REG = 8,
    localparam int DEPTH  = NUM_CH * NUM_OP * NUM_REG,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] op_rd,
    output logic              dly_rise,
    output logic              dly_fall
);
    localparam int RG_W  = $clog2(NUM_REG);
    localparam int NSLOT = NUM_CH * NUM_OP;
    localparam int SL_W  = IDX_W - RG_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] raw_q;
    logic [RG_W-1:0]   rg_q;
    logic [2:0]        dly_sh [NSLOT];
    logic [SL_W-1:0]   slot;
    logic [2:0]        new_dly;
    logic [2:0]        old_dly;

    assign slot    = idx[IDX_W-1:RG_W];
    assign new_dly = wdata[7:5];
    assign old_dly = dly_sh[slot];

    // RAM write and registered read (storage itself is not reset)
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) begin
            raw_q <= mem[idx];
            rg_q  <= idx[RG_W-1:0];
        end
    end

    // Delay shadow update and transition pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) dly_sh[i] <= '0;
            dly_rise <= 1'b0;
            dly_fall <= 1'b0;
        end else begin
            dly_rise <= 1'b0;
            dly_fall <= 1'b0;
            if (we && idx[RG_W-1:0] == RG_W'(DLY_REG)) begin
                dly_sh[slot] <= new_dly;
                dly_rise     <= new_dly > old_dly;
                dly_fall     <= new_dly < old_dly;
            end
        end
    end

    // Readback substitution: byte 0 returns bit 6 in place of bit 4
    assign op_rd = (rg_q == RG_W'(MODE_REG)) ? {raw_q[7:5], raw_q[6], raw_q[3:0]} : raw_q;
endmodule

// File: rtl/fmnr_chan_ctl.sv
// Channel key-on / four-operator flops, split halves of the top channels,
// and the global mode and test registers, plus their combinational readback.
// Assumes region/ch/half come from fmnr_decode for the current address.
module fmnr_chan_ctl
    import fmnr_pkg::*;
#(
    parameter int NUM_CH   = 18,
    parameter int SPLIT_CH = 2,
    parameter int QUAD_GRP = 3,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  region_e             region,
    input  logic [CH_W-1:0]     ch,
    input  logic                half,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_CH-1:0]   key_on,
    output logic [NUM_CH-1:0]   fourop,
    output logic [SPLIT_CH-1:0] key_on_hi,
    output logic [SPLIT_CH-1:0] fourop_hi,
    output logic                ks_mode,
    output logic                eg_halt,
    output logic [DATA_W-1:0]   ctl_rd
);
    localparam int HALF_CH = NUM_CH / 2;
    localparam int SB_W    = (SPLIT_CH > 1) ? $clog2(SPLIT_CH) : 1;

    logic              pair_wr;
    logic              quad_wr;
    logic [7:0]        test_raw;
    logic [SB_W-1:0]   sidx;
    logic [2*QUAD_GRP-1:0] quad_rd;

    assign pair_wr = wr_en && (region == RG_KEY || (region == RG_SPLIT && !half));
    assign quad_wr = wr_en && (region == RG_QUAD);
    assign sidx    = SB_W'(ch - CH_W'(NUM_CH - SPLIT_CH));

    // Per-channel key-on / four-operator flops
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int QB = (g < QUAD_GRP) ? g :
                            (g >= HALF_CH && g < HALF_CH + QUAD_GRP) ? QUAD_GRP + g - HALF_CH : -1;
        logic k_r, q_r;
        if (QB >= 0) begin : g_quad
            // Channel reachable from both its pair address and the group register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    k_r <= 1'b0;
                    q_r <= 1'b0;
                end else if (pair_wr && ch == CH_W'(g)) begin
                    k_r <= wdata[0];
                    q_r <= wdata[1];
                end else if (quad_wr) begin
                    q_r <= wdata[QB];
                end
            end
        end else begin : g_plain
            // Channel reachable only from its pair address
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    k_r <= 1'b0;
                    q_r <= 1'b0;
                end else if (pair_wr && ch == CH_W'(g)) begin
                    k_r <= wdata[0];
                    q_r <= wdata[1];
                end
            end
        end
        assign key_on[g] = k_r;
        assign fourop[g] = q_r;
    end

    // Second-half pairs of the split channels
    for (genvar h = 0; h < SPLIT_CH; h++) begin : g_hi
        logic k_r, q_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                k_r <= 1'b0;
                q_r <= 1'b0;
            end else if (wr_en && region == RG_SPLIT && half && ch == CH_W'(NUM_CH - SPLIT_CH + h)) begin
                k_r <= wdata[0];
                q_r <= wdata[1];
            end
        end
        assign key_on_hi[h] = k_r;
        assign fourop_hi[h] = q_r;
    end

    // Group register readback vector
    for (genvar q = 0; q < QUAD_GRP; q++) begin : g_qrd
        assign quad_rd[q]            = fourop[q];
        assign quad_rd[QUAD_GRP + q] = fourop[HALF_CH + q];
    end

    // Global mode and test registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_mode  <= 1'b0;
            test_raw <= '0;
        end else if (wr_en && region == RG_KSMODE) begin
            ks_mode  <= wdata[6];
        end else if (wr_en && region == RG_TEST) begin
            test_raw <= wdata;
        end
    end

    assign eg_halt = test_raw[0] | test_raw[5];

    // Readback value for non-operator regions
    always_comb begin
        ctl_rd = '0;
        case (region)
            RG_KEY:    ctl_rd = {6'b0, fourop[ch], key_on[ch]};
            RG_SPLIT:  ctl_rd = half ? {6'b0, fourop_hi[sidx], key_on_hi[sidx]}
                                     : {6'b0, fourop[ch], key_on[ch]};
            RG_KSMODE: ctl_rd = {1'b0, ks_mode, 6'b0};
            RG_TEST:   ctl_rd = {test_raw[7:6], eg_halt, test_raw[4:1], test_raw[5]};
            RG_QUAD:   ctl_rd[2*QUAD_GRP-1:0] = quad_rd;
            default:   ctl_rd = '0;
        endcase
    end
endmodule

// File: rtl/fmnr_regfile.sv
// Top of the FM native register file: decodes the address, routes writes to
// operator storage or channel/global flops, and registers the readback so
// every read completes one cycle after its strobe.
// Assumes at most one of wr_en / rd_en per cycle to the same address.
module fmnr_regfile
    import fmnr_pkg::*;
#(
    parameter int NUM_CH   = 18,
    parameter int NUM_OP   = 4,
    parameter int NUM_REG  = 8,
    parameter int SPLIT_CH = 2,
    parameter int QUAD_GRP = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [10:0]         addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic                rd_valid,
    output logic                dly_rise,
    output logic                dly_fall,
    output logic [NUM_CH-1:0]   key_on,
    output logic [NUM_CH-1:0]   fourop,
    output logic [SPLIT_CH-1:0] key_on_hi,
    output logic [SPLIT_CH-1:0] fourop_hi,
    output logic                ks_mode,
    output logic                eg_halt
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int IDX_W = $clog2(NUM_CH * NUM_OP * NUM_REG);

    region_e           region;
    logic [CH_W-1:0]   ch;
    logic              half;
    logic [DATA_W-1:0] op_rd;
    logic [DATA_W-1:0] ctl_rd;
    logic [DATA_W-1:0] misc_q;
    logic              src_op_q;

    fmnr_decode #(
        .NUM_CH(NUM_CH), .NUM_OP(NUM_OP), .NUM_REG(NUM_REG), .SPLIT_CH(SPLIT_CH)
    ) u_dec (
        .addr(addr), .region(region), .ch(ch), .half(half)
    );

    fmnr_op_store #(
        .NUM_CH(NUM_CH), .NUM_OP(NUM_OP), .NUM_REG(NUM_REG)
    ) u_ops (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && region == RG_OPER),
        .re(rd_en && region == RG_OPER),
        .idx(addr[IDX_W-1:0]), .wdata(wdata),
        .op_rd(op_rd), .dly_rise(dly_rise), .dly_fall(dly_fall)
    );

    fmnr_chan_ctl #(
        .NUM_CH(NUM_CH), .SPLIT_CH(SPLIT_CH), .QUAD_GRP(QUAD_GRP)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .region(region),
        .ch(ch), .half(half), .wdata(wdata),
        .key_on(key_on), .fourop(fourop),
        .key_on_hi(key_on_hi), .fourop_hi(fourop_hi),
        .ks_mode(ks_mode), .eg_halt(eg_halt), .ctl_rd(ctl_rd)
    );

    // Read pipeline: capture source select and non-RAM data with the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            src_op_q <= 1'b0;
            misc_q   <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                src_op_q <= (region == RG_OPER);
                misc_q   <= ctl_rd;
            end
        end
    end

    assign rdata = src_op_q ? op_rd : misc_q;
endmodule

// File: rtl/fmnr_regfile_chk.sv
// Property checker for fmnr_regfile, attached with bind below.
// Assumes the default 11-bit address map and fixed global addresses.
module fmnr_regfile_chk
    import fmnr_pkg::*;
#(
    parameter int NUM_CH   = 18,
    parameter int NUM_OP   = 4,
    parameter int NUM_REG  = 8,
    parameter int SPLIT_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [10:0]       addr,
    input logic              rd_valid,
    input logic              dly_rise,
    input logic              dly_fall,
    input logic [NUM_CH-1:0] key_on,
    input logic [NUM_CH-1:0] fourop,
    input logic              ks_mode,
    input logic              eg_halt
);
    localparam int OPER_SPAN = NUM_CH * NUM_OP * NUM_REG;
    localparam int MAP_END   = OPER_SPAN + NUM_CH + SPLIT_CH;

    logic dly_write;
    logic hole_write;

    assign dly_write  = wr_en && (int'(addr) < OPER_SPAN) && (addr[2:0] == 3'(DLY_REG));
    assign hole_write = wr_en && (int'(addr) >= MAP_END) &&
                        addr != A_KSMODE && addr != A_TEST && addr != A_QUAD;

    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(dly_rise && dly_fall));
    a_r4_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_write |=> (!dly_rise && !dly_fall));
    a_r8_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_KSMODE) |=> $stable(ks_mode));
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_TEST) |=> $stable(eg_halt));
    a_r10_hole_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        hole_write |=> ($stable(key_on) && $stable(fourop) && $stable(ks_mode) && $stable(eg_halt)));
endmodule

bind fmnr_regfile fmnr_regfile_chk #(
    .NUM_CH(NUM_CH), .NUM_OP(NUM_OP), .NUM_REG(NUM_REG), .SPLIT_CH(SPLIT_CH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .rd_valid(rd_valid), .dly_rise(dly_rise), .dly_fall(dly_fall),
    .key_on(key_on), .fourop(fourop), .ks_mode(ks_mode), .eg_halt(eg_halt)
);

// File: tb/fmnr_regfile_tb.sv
// Directed bench for fmnr_regfile: one task per scenario, each self-checking.
module fmnr_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [10:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        rd_valid, dly_rise, dly_fall;
    logic [17:0] key_on, fourop;
    logic [1:0]  key_on_hi, fourop_hi;
    logic        ks_mode, eg_halt;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    fmnr_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .dly_rise(dly_rise), .dly_fall(dly_fall),
        .key_on(key_on), .fourop(fourop), .key_on_hi(key_on_hi), .fourop_hi(fourop_hi),
        .ks_mode(ks_mode), .eg_halt(eg_halt)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] v, output logic vld);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata; vld = rd_valid;
    endtask

    task automatic t_reset();
        logic [7:0] v; logic vld;
        chk("R1", "key_on", 32'(key_on), 0);
        chk("R1", "fourop", 32'(fourop), 0);
        chk("R1", "hi halves", 32'({key_on_hi, fourop_hi}), 0);
        chk("R1", "ks_mode/eg_halt", 32'({ks_mode, eg_halt}), 0);
        chk("R1", "pulses/valid", 32'({dly_rise, dly_fall, rd_valid}), 0);
        rd(11'd576, v, vld);
        chk("R1", "read 576", 32'(v), 32'h00);
    endtask

    task automatic t_oper();
        logic [7:0] v; logic vld;
        wr(11'd114, 8'hA5);   // ch3 op2 byte2
        wr(11'd575, 8'h3C);   // ch17 op3 byte7
        wr(11'd4,   8'h81);   // ch0 op0 byte4
        rd(11'd114, v, vld);
        chk("R2", "rd 114", 32'(v), 32'hA5);
        chk("R2", "rd_valid", 32'(vld), 1);
        rd(11'd575, v, vld);
        chk("R2", "rd 575", 32'(v), 32'h3C);
        rd(11'd4, v, vld);
        chk("R2", "rd 4", 32'(v), 32'h81);
        @(negedge clk);
        chk("R2", "rd_valid idle", 32'(rd_valid), 0);
    endtask

    task automatic t_mode_byte();
        logic [7:0] v; logic vld;
        wr(11'd8, 8'h4F);
        rd(11'd8, v, vld);
        chk("R3", "byte0 bit6 set", 32'(v), 32'h5F);
        wr(11'd8, 8'h90);
        rd(11'd8, v, vld);
        chk("R3", "byte0 bit4 set", 32'(v), 32'h80);
    endtask

    task automatic t_delay();
        logic [7:0] v; logic vld;
        wr(11'd77, 8'h60);   // ch2 op1 byte5, delay 0->3
        chk("R4", "rise 0->3", 32'({dly_rise, dly_fall}), 32'b10);
        @(negedge clk);
        chk("R4", "pulse one cycle", 32'({dly_rise, dly_fall}), 0);
        wr(11'd77, 8'h7F);   // delay stays 3
        chk("R4", "equal delay", 32'({dly_rise, dly_fall}), 0);
        wr(11'd77, 8'h20);   // 3->1
        chk("R4", "fall 3->1", 32'({dly_rise, dly_fall}), 32'b01);
        wr(11'd76, 8'hFF);   // byte4: no compare
        chk("R4", "byte4 no pulse", 32'({dly_rise, dly_fall}), 0);
        wr(11'd77, 8'hE0);   // 1->7
        chk("R4", "rise 1->7", 32'({dly_rise, dly_fall}), 32'b10);
        wr(11'd5, 8'h20);    // ch0 op0, own shadow 0->1
        chk("R4", "independent op", 32'({dly_rise, dly_fall}), 32'b10);
        rd(11'd77, v, vld);
        chk("R4", "byte5 readback", 32'(v), 32'hE0);
    endtask

    task automatic t_keyon();
        logic [7:0] v; logic vld;
        wr(11'd581, 8'h03);
        chk("R5", "ch5 key/4op", 32'({fourop[5], key_on[5]}), 32'b11);
        rd(11'd581, v, vld);
        chk("R5", "rd 581", 32'(v), 32'h03);
        wr(11'd581, 8'hFE);
        chk("R5", "ch5 key off", 32'({fourop[5], key_on[5]}), 32'b10);
        rd(11'd581, v, vld);
        chk("R5", "rd 581 masked", 32'(v), 32'h02);
        wr(11'd591, 8'h01);
        chk("R5", "ch15 key", 32'(key_on[15]), 1);
    endtask

    task automatic t_split();
        logic [7:0] v; logic vld;
        wr(11'd592, 8'h01);
        wr(11'd593, 8'h02);
        wr(11'd594, 8'h03);
        wr(11'd595, 8'h01);
        chk("R6", "main 16/17", 32'({fourop[17:16], key_on[17:16]}), 32'b1011);
        chk("R6", "hi halves", 32'({fourop_hi, key_on_hi}), 32'b0110);
        rd(11'd593, v, vld);
        chk("R6", "rd 593", 32'(v), 32'h02);
        rd(11'd594, v, vld);
        chk("R6", "rd 594", 32'(v), 32'h03);
    endtask

    task automatic t_quad();
        logic [7:0] v; logic vld;
        wr(11'h504, 8'h2D);
        chk("R7", "fourop 2:0", 32'(fourop[2:0]), 32'b101);
        chk("R7", "fourop 11:9", 32'(fourop[11:9]), 32'b101);
        chk("R7", "fourop 5 kept", 32'(fourop[5]), 1);
        rd(11'h504, v, vld);
        chk("R7", "rd 504", 32'(v), 32'h2D);
        wr(11'h504, 8'hC0);
        rd(11'h504, v, vld);
        chk("R7", "rd 504 top ignored", 32'(v), 32'h00);
    endtask

    task automatic t_ksmode();
        logic [7:0] v; logic vld;
        wr(11'h408, 8'hFF);
        chk("R8", "ks_mode set", 32'(ks_mode), 1);
        rd(11'h408, v, vld);
        chk("R8", "rd 408", 32'(v), 32'h40);
        wr(11'h408, 8'hBF);
        chk("R8", "ks_mode clear", 32'(ks_mode), 0);
    endtask

    task automatic t_test();
        logic [7:0] v; logic vld;
        wr(11'h501, 8'h01);
        chk("R9", "halt from bit0", 32'(eg_halt), 1);
        rd(11'h501, v, vld);
        chk("R9", "rd 501 w01", 32'(v), 32'h20);
        wr(11'h501, 8'h20);
        chk("R9", "halt from bit5", 32'(eg_halt), 1);
        rd(11'h501, v, vld);
        chk("R9", "rd 501 w20", 32'(v), 32'h21);
        wr(11'h501, 8'h9E);
        chk("R9", "halt clear", 32'(eg_halt), 0);
        rd(11'h501, v, vld);
        chk("R9", "rd 501 w9E", 32'(v), 32'h9E);
    endtask

    task automatic t_holes();
        logic [7:0] v; logic vld;
        logic [17:0] k0, q0;
        logic [1:0]  kh0, qh0;
        k0 = key_on; q0 = fourop; kh0 = key_on_hi; qh0 = fourop_hi;
        wr(11'd596, 8'hFF);
        wr(11'h600, 8'hFF);
        wr(11'h7FF, 8'hFF);
        wr(11'h409, 8'hFF);
        chk("R10", "key_on unchanged", 32'(key_on), 32'(k0));
        chk("R10", "fourop unchanged", 32'(fourop), 32'(q0));
        chk("R10", "hi unchanged", 32'({key_on_hi, fourop_hi}), 32'({kh0, qh0}));
        chk("R10", "globals unchanged", 32'({ks_mode, eg_halt}), 0);
        rd(11'h408, v, vld);
        chk("R10", "rd 408 unchanged", 32'(v), 32'h00);
        rd(11'd596, v, vld);
        chk("R10", "rd 596", 32'(v), 32'h00);
        rd(11'h7FF, v, vld);
        chk("R10", "rd 7FF", 32'(v), 32'h00);
        rd(11'h505, v, vld);
        chk("R10", "rd 505", 32'(v), 32'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oper();
        t_mode_byte();
        t_delay();
        t_keyon();
        t_split();
        t_quad();
        t_ksmode();
        t_test();
        t_holes();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule